// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output-compare channel that sits next to an up/down timer counter kept elsewhere in the design. Each clock it looks at the counter value, the count direction and an active compare value, and from the current compare mode it works out a registered reference waveform. The mode may be one of eight: hold, set on match, clear on match, toggle on match, force low, force high, and two PWM modes that are the inverse of each other, where the PWM comparison depends on the direction of counting.

The compare value is loaded through its own write strobe. When preload is enabled in the control word, a written value first goes into a shadow register and only becomes active on the next update-event pulse. When preload is disabled, the write takes effect at once. The 32-bit control word is written over a simple register write port and can always be read back.

Top module: `cmp_out_channel`

## Requirements
- R1: After reset the control word reads 0 (hold mode, channel selection 00, preload off) and `refOut` is 0.
- R2: Mode 0 (control bits 6:4 = 000) keeps `refOut` at its value, whatever the counter and compare values are.
- R3: Mode 1 sets `refOut` to 1 in the cycle after the counter equals the active compare value. Mode 2 clears it to 0 on that match. With no match, `refOut` holds.
- R4: Mode 3 inverts `refOut` once for every clock in which the counter equals the active compare value.
- R5: Mode 4 forces `refOut` to 0 and mode 5 forces it to 1, whatever the compare result.
- R6: Mode 6 with `cntDown`=0 gives `refOut` = 1 when counter < compare and 0 otherwise. With `cntDown`=1 it gives 0 when counter > compare and 1 otherwise.
- R7: Mode 7 gives the logical inverse of the mode 6 result for the same counter, compare value and direction.
- R8: With control bit 3 (preload) set, a compare write goes to a shadow register and becomes active on the next `updEvt` pulse. With bit 3 clear, a compare write is active from the next cycle.
- R9: When control bits 1:0 (channel selection) are not 00, `refOut` holds at its value in every mode.
- R10: A control write stores bits 16 and 6:0 and clears every other bit. Bit 16 and bit 2 (fast enable) are read back but do not change `refOut`.
- R11: `refOut` is a register: it reflects the inputs of the previous clock. A control write takes effect on the clock edge after the one that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cnt | input | CNT_W | Counter value from the external timer |
| cntDown | input | 1 | 1 when the counter is counting down |
| updEvt | input | 1 | Update-event pulse that moves the shadow compare value into the active one |
| cmpWrEn | input | 1 | Compare-value write strobe |
| cmpWrData | input | CNT_W | Compare value to write |
| ctlWrEn | input | 1 | Control-word write strobe |
| ctlWrData | input | 32 | Control word to write |
| ctlRdData | output | 32 | Stored control word |
| refOut | output | 1 | Registered reference waveform |

## Verification
A control or compare write is stored at the edge where its strobe is high. The counter value presented in the next cycle then sets `refOut` at the edge after that. So a result is due one edge after the counter value that caused it, and two edges after the write that picked the mode. The bench drives inputs on falling edges, advances one rising edge per step, and samples `refOut` at the falling edge that follows. Each expected value is matched to the counter and direction of the step just taken. The sweep tries both PWM modes against every counter and compare pair of a 4-bit configuration, in both directions. The preload check samples once before and once after the update pulse, with the same counter, to show in which cycle the new compare value takes hold.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

  localparam int CTL_W = 32;
  // Bits kept by a control write: bit 16 and bits 6:0.
  localparam logic [CTL_W-1:0] CTL_KEEP_MASK = 32'h0001_007F;
  localparam int MODE_LSB    = 4;
  localparam int PRELOAD_BIT = 3;
  localparam int FAST_BIT    = 2;
  localparam int SEL_LSB     = 0;
  localparam int SEL_W       = 2;
  localparam int MODE_W      = 3;
  localparam int EXTRA_BIT   = 16;

  typedef enum logic [MODE_W-1:0] {
    MODE_HOLD  = 3'd0,
    MODE_SET   = 3'd1,
    MODE_CLR   = 3'd2,
    MODE_FLIP  = 3'd3,
    MODE_LOW   = 3'd4,
    MODE_HIGH  = 3'd5,
    MODE_PWM_A = 3'd6,
    MODE_PWM_B = 3'd7
  } ocMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic forceHi;
    logic forceLo;
    logic matchSet;
    logic matchClr;
    logic matchFlip;
    logic pwmEn;
    logic pwmInv;
    logic cmpDirect;
    logic cmpShadow;
    logic cmpPromote;
  } ocStrobe_t;

endpackage

// File: rtl/cmp_out_ctrl.sv
module cmp_out_ctrl
  import cmp_out_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             cmpWrEn,
  input  logic             updEvt,
  output logic [CTL_W-1:0] ctlRdData,
  output ocStrobe_t        strobe
);

  logic [CTL_W-1:0] ctlReg;
  ocMode_e          mode;
  logic             preloadOn;
  logic             outputSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
    end else if (ctlWrEn) begin
      ctlReg <= ctlWrData & CTL_KEEP_MASK;
    end
  end

  assign ctlRdData = ctlReg;
  assign mode      = ocMode_e'(ctlReg[MODE_LSB +: MODE_W]);
  assign preloadOn = ctlReg[PRELOAD_BIT];
  assign outputSel = (ctlReg[SEL_LSB +: SEL_W] == '0);

  always_comb begin
    strobe = '0;
    // compare-value loading works whatever the mode is
    strobe.cmpShadow  = cmpWrEn;
    strobe.cmpDirect  = cmpWrEn && !preloadOn;
    strobe.cmpPromote = updEvt && preloadOn;
    if (outputSel) begin
      case (mode)
        MODE_SET:   strobe.matchSet  = 1'b1;
        MODE_CLR:   strobe.matchClr  = 1'b1;
        MODE_FLIP:  strobe.matchFlip = 1'b1;
        MODE_LOW:   strobe.forceLo   = 1'b1;
        MODE_HIGH:  strobe.forceHi   = 1'b1;
        MODE_PWM_A: strobe.pwmEn     = 1'b1;
        MODE_PWM_B: begin
          strobe.pwmEn  = 1'b1;
          strobe.pwmInv = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cmp_out_dpath.sv
module cmp_out_dpath
  import cmp_out_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntDown,
  input  logic [CNT_W-1:0] cmpWrData,
  input  ocStrobe_t        strobe,
  output logic             refOut
);

  logic [CNT_W-1:0] cmpShadow;
  logic [CNT_W-1:0] cmpActive;
  logic             isEq;
  logic             isLt;
  logic             isGt;
  logic             pwmRaw;
  logic             refNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpShadow <= '0;
      cmpActive <= '0;
    end else begin
      if (strobe.cmpShadow) cmpShadow <= cmpWrData;
      if (strobe.cmpDirect)       cmpActive <= cmpWrData;
      else if (strobe.cmpPromote) cmpActive <= cmpShadow;
    end
  end

  assign isEq = (cnt == cmpActive);
  assign isLt = (cnt <  cmpActive);
  assign isGt = (cnt >  cmpActive);

  // Up: high below compare. Down: low above compare.
  assign pwmRaw = cntDown ? !isGt : isLt;

  always_comb begin
    refNext = refOut;
    if (strobe.forceHi)                  refNext = 1'b1;
    else if (strobe.forceLo)             refNext = 1'b0;
    else if (strobe.pwmEn)               refNext = pwmRaw ^ strobe.pwmInv;
    else if (strobe.matchSet  && isEq)   refNext = 1'b1;
    else if (strobe.matchClr  && isEq)   refNext = 1'b0;
    else if (strobe.matchFlip && isEq)   refNext = !refOut;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refOut <= 1'b0;
    else       refOut <= refNext;
  end

endmodule

// File: rtl/cmp_out_channel.sv
module cmp_out_channel
  import cmp_out_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntDown,
  input  logic             updEvt,
  input  logic             cmpWrEn,
  input  logic [CNT_W-1:0] cmpWrData,
  input  logic             ctlWrEn,
  input  logic [31:0]      ctlWrData,
  output logic [31:0]      ctlRdData,
  output logic             refOut
);

  ocStrobe_t strobe;

  cmp_out_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .cmpWrEn   (cmpWrEn),
    .updEvt    (updEvt),
    .ctlRdData (ctlRdData),
    .strobe    (strobe)
  );

  cmp_out_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .cnt       (cnt),
    .cntDown   (cntDown),
    .cmpWrData (cmpWrData),
    .strobe    (strobe),
    .refOut    (refOut)
  );

endmodule

// File: rtl/cmp_out_channel_chk.sv
module cmp_out_channel_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] mode,
  input logic [1:0] sel,
  input logic       refOut
);

  // R2: hold mode keeps the output
  p_frozen_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0) |=> $stable(refOut));

  // R3: set-on-match never lowers the output
  p_set_never_falls_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd1) |=> !$fell(refOut));

  // R3: clear-on-match never raises the output
  p_clr_never_rises_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2) |=> !$rose(refOut));

  // R5: forced low
  p_force_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd4 && sel == 2'b00) |=> !refOut);

  // R5: forced high
  p_force_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd5 && sel == 2'b00) |=> refOut);

  // R9: non-output selection holds the output
  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sel != 2'b00) |=> $stable(refOut));

endmodule

bind cmp_out_channel cmp_out_channel_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .mode   (ctlRdData[6:4]),
  .sel    (ctlRdData[1:0]),
  .refOut (refOut)
);

// File: tb/cmp_out_channel_bench.sv
`timescale 1ns/1ps
module cmp_out_channel_bench;

  localparam int CW = 4;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] cnt = '0;
  logic          cntDown = 1'b0;
  logic          updEvt = 1'b0;
  logic          cmpWrEn = 1'b0;
  logic [CW-1:0] cmpWrData = '0;
  logic          ctlWrEn = 1'b0;
  logic [31:0]   ctlWrData = '0;
  logic [31:0]   ctlRdData;
  logic          refOut;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cmp_out_channel #(.CNT_W(CW)) u_cmp_out_channel (
    .clk(clk), .rstN(rstN), .cnt(cnt), .cntDown(cntDown), .updEvt(updEvt),
    .cmpWrEn(cmpWrEn), .cmpWrData(cmpWrData), .ctlWrEn(ctlWrEn),
    .ctlWrData(ctlWrData), .ctlRdData(ctlRdData), .refOut(refOut)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeCtl(input logic [31:0] v);
    ctlWrEn = 1'b1; ctlWrData = v;
    tick();
    ctlWrEn = 1'b0;
  endtask

  task automatic writeCmp(input logic [CW-1:0] v);
    cmpWrEn = 1'b1; cmpWrData = v;
    tick();
    cmpWrEn = 1'b0;
  endtask

  task automatic step(input logic [CW-1:0] c, input logic dn);
    cnt = c; cntDown = dn;
    tick();
  endtask

  function automatic logic pwmExp(input int c, input int k, input logic dn, input logic inv);
    logic r;
    r = dn ? !(c > k) : (c < k);
    return r ^ inv;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 ctl reset", ctlRdData, 32'h0);
    check("R1 ref reset", {31'b0, refOut}, 32'h0);
    rstN = 1'b1;
    tick();

    // R2: hold mode from reset, counter sweeps through the match
    writeCmp(4'd3);
    for (int c = 0; c <= MAXV; c++) begin
      step(c[CW-1:0], 1'b0);
      check("R2 hold low", {31'b0, refOut}, 32'h0);
    end

    // R5 force high, R11 one edge of latency after the control write
    writeCtl(32'h50);
    check("R11 not yet", {31'b0, refOut}, 32'h0);
    step(4'd0, 1'b0);
    check("R5 force high", {31'b0, refOut}, 32'h1);
    writeCtl(32'h00);
    for (int c = 0; c <= MAXV; c++) begin
      step(c[CW-1:0], 1'b1);
      check("R2 hold high", {31'b0, refOut}, 32'h1);
    end
    writeCtl(32'h40);
    step(4'd3, 1'b0);
    check("R5 force low at match", {31'b0, refOut}, 32'h0);

    // R3 set / clear on match, compare = 7
    writeCmp(4'd7);
    writeCtl(32'h10);
    step(4'd3, 1'b0);
    check("R3 set no match", {31'b0, refOut}, 32'h0);
    step(4'd7, 1'b0);
    check("R3 set on match", {31'b0, refOut}, 32'h1);
    step(4'd8, 1'b0);
    check("R3 set stays", {31'b0, refOut}, 32'h1);
    writeCtl(32'h20);
    step(4'd6, 1'b0);
    check("R3 clr no match", {31'b0, refOut}, 32'h1);
    step(4'd7, 1'b0);
    check("R3 clr on match", {31'b0, refOut}, 32'h0);

    // R4 toggle: each matching clock flips the output
    writeCtl(32'h30);
    for (int i = 0; i < 4; i++) begin
      step(4'd7, 1'b0);
      check("R4 toggle", {31'b0, refOut}, (i % 2 == 0) ? 32'h1 : 32'h0);
    end
    step(4'd2, 1'b0);
    check("R4 no match hold", {31'b0, refOut}, 32'h0);

    // R9 channel selection not output: forced high is ignored
    for (int s = 1; s < 4; s++) begin
      writeCtl(32'h50 | s);
      step(4'd0, 1'b0);
      step(4'd7, 1'b1);
      check("R9 sel hold", {31'b0, refOut}, 32'h0);
    end

    // R10 read-back mask
    writeCtl(32'hFFFF_FFFF);
    check("R10 readback", ctlRdData, 32'h0001_007F);
    writeCtl(32'h0000_0000);

    // R6 / R7 exhaustive sweep, both directions
    for (int m = 6; m <= 7; m++) begin
      writeCtl(m << 4);
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k <= MAXV; k++) begin
          writeCmp(k[CW-1:0]);
          for (int c = 0; c <= MAXV; c++) begin
            step(c[CW-1:0], d[0]);
            check(m == 6 ? "R6 pwm" : "R7 pwm inverse", {31'b0, refOut},
                  {31'b0, pwmExp(c, k, d[0], m[0])});
          end
        end
      end
    end

    // R10: bit 16 and fast enable do not change the PWM result
    writeCtl(32'h0001_0064);
    writeCmp(4'd9);
    for (int c = 0; c <= MAXV; c++) begin
      step(c[CW-1:0], 1'b0);
      check("R10 extra bits no effect", {31'b0, refOut}, {31'b0, pwmExp(c, 9, 1'b0, 1'b0)});
    end

    // R8 preload
    writeCtl(32'h60);
    writeCmp(4'd10);
    writeCtl(32'h68);
    writeCmp(4'd3);
    step(4'd5, 1'b0);
    check("R8 shadow not active", {31'b0, refOut}, 32'h1);
    updEvt = 1'b1;
    step(4'd5, 1'b0);
    updEvt = 1'b0;
    step(4'd5, 1'b0);
    check("R8 active after update", {31'b0, refOut}, 32'h0);
    writeCtl(32'h60);
    writeCmp(4'd12);
    step(4'd5, 1'b0);
    check("R8 direct write", {31'b0, refOut}, 32'h1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule